// File: doc/BRIEF.md
# Three-State Power Mode Sequencer

This block sequences a chip between three power states. In the run state everything operates normally. In the sleep state the CPU clock is stopped, external memory is held in self-refresh, and only the display keeps refreshing from a small low-power buffer. In the intermediate state the CPU runs at full speed and memory refresh is back to normal, but the display still shows the low-power buffer.

Software enters sleep by writing a sleep-entry location, which the block sees as a one-cycle strobe. A wake or interrupt event brings the block out of sleep, always into the intermediate state. From there, software either writes the sleep-entry location again to go back to sleep, or clears the display-mode flag to reach the run state. The display-mode flag tells the display engine to use the low-power buffer. Only hardware can set it, and it does so on entry to sleep. Software can only clear it.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the state is run (`state` = 2'b00), `disp_lowpwr` = 0, `self_refresh` = 0 and `cpu_clk_en` = 1. The state code is 2'b00 for run, 2'b01 for sleep and 2'b10 for intermediate.
- R2: A `sleep_wr` pulse in the run state moves the block to sleep at that clock edge, and `disp_lowpwr` becomes 1 at the same edge.
- R3: In sleep, a `wake_evt` or `irq_evt` pulse moves the block to the intermediate state, never directly to run. A `sleep_wr` pulse in sleep has no effect.
- R4: The intermediate state is entered only from sleep. Wake and interrupt events in the run state or the intermediate state leave the state unchanged.
- R5: A `dmode_wr` with `dmode_wdata` = 1 is ignored in every state. A `dmode_wr` with `dmode_wdata` = 0 clears `disp_lowpwr` in the run and intermediate states. All `dmode_wr` writes are ignored in sleep.
- R6: In the intermediate state, clearing the display-mode flag moves the block to run at the same edge.
- R7: In the intermediate state, a `sleep_wr` pulse while `disp_lowpwr` = 1 returns the block to sleep.
- R8: `self_refresh` is 1 exactly when the state is sleep. It drops at the same edge that enters the intermediate state.
- R9: `cpu_clk_en` is 0 exactly when the state is sleep.
- R10: When a wake or interrupt event and `sleep_wr` arrive in the same cycle, the event wins. The block stays in run, or stays in the intermediate state.
- R11: In the intermediate state, a flag-clear write in the same cycle as `sleep_wr` wins, and the block goes to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_wr | input | 1 | Strobe: software write to the sleep-entry location |
| wake_evt | input | 1 | Wake event pulse |
| irq_evt | input | 1 | Interrupt event pulse |
| dmode_wr | input | 1 | Strobe: software write to the display-mode flag |
| dmode_wdata | input | 1 | Value carried by the display-mode write |
| state | output | 2 | Current power state code |
| self_refresh | output | 1 | External memory self-refresh enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| disp_lowpwr | output | 1 | Display-mode flag: the display engine uses the low-power buffer |

## Verification
Every result is registered. A stimulus applied during cycle k shows on `state`, `disp_lowpwr`, `self_refresh` and `cpu_clk_en` right after the rising edge that ends cycle k: a latency of exactly one edge, with no result showing up a cycle later. The bench drives its inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. So each check looks at the cycle the result is due in, and outputs that must hold still are read again after further edges.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_wr,
  input  logic               wake_evt,
  input  logic               irq_evt,
  input  logic               dmode_wr,
  input  logic               dmode_wdata,
  output logic [STATE_W-1:0] state,
  output logic               self_refresh,
  output logic               cpu_clk_en,
  output logic               disp_lowpwr
);

  localparam logic [STATE_W-1:0] ST_RUN   = STATE_W'(0);
  localparam logic [STATE_W-1:0] ST_SLEEP = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_INTER = STATE_W'(2);

  logic               evt;
  logic               clr_req;
  logic [STATE_W-1:0] nxt_state;
  logic               nxt_flag;

  assign evt     = wake_evt | irq_evt;
  assign clr_req = dmode_wr & ~dmode_wdata;

  always_comb begin
    nxt_state = state;
    nxt_flag  = disp_lowpwr;
    case (state)
      ST_RUN: begin
        if (clr_req) nxt_flag = 1'b0;
        if (sleep_wr && !evt) begin
          nxt_state = ST_SLEEP;
          nxt_flag  = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (evt) nxt_state = ST_INTER;
      end
      ST_INTER: begin
        if (clr_req) begin
          nxt_flag  = 1'b0;
          nxt_state = ST_RUN;
        end else if (sleep_wr && !evt && disp_lowpwr) begin
          nxt_state = ST_SLEEP;
        end
      end
      default: begin
        nxt_state = ST_RUN;
        nxt_flag  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      disp_lowpwr  <= 1'b0;
      self_refresh <= 1'b0;
      cpu_clk_en   <= 1'b1;
    end else begin
      state        <= nxt_state;
      disp_lowpwr  <= nxt_flag;
      self_refresh <= (nxt_state == ST_SLEEP);
      cpu_clk_en   <= (nxt_state != ST_SLEEP);
    end
  end

  assert_sleep_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SLEEP |=> (state == ST_SLEEP || state == ST_INTER));

  assert_inter_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RUN |=> state != ST_INTER);

  assert_flag_set_on_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_lowpwr) |-> (state == ST_SLEEP && $past(state) == ST_RUN));

  assert_flag_held_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SLEEP |-> disp_lowpwr);

  assert_sref_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh == (state == ST_SLEEP));

  assert_cken_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en == !self_refresh);

  assert_to_run_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTER && clr_req) |=> (state == ST_RUN && !disp_lowpwr));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_wr = 0, wake_evt = 0, irq_evt = 0, dmode_wr = 0, dmode_wdata = 0;
  logic [1:0] state;
  logic self_refresh, cpu_clk_en, disp_lowpwr;
  int n_chk = 0, n_bad = 0;

  localparam logic [1:0] RUN = 2'b00, SLP = 2'b01, INT = 2'b10;

  pwr_mode_seq uut (.clk, .rst_n, .sleep_wr, .wake_evt, .irq_evt, .dmode_wr,
    .dmode_wdata, .state, .self_refresh, .cpu_clk_en, .disp_lowpwr);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_all(string req, logic [1:0] st, logic fl);
    logic [4:0] got, exp;
    got = {state, disp_lowpwr, self_refresh, cpu_clk_en};
    exp = {st, fl, st == SLP, st != SLP};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got st/flag/sref/cken=%b expected %b", req, got, exp);
    end
  endtask

  task automatic cycle(logic s, logic w, logic i, logic dw, logic dd);
    sleep_wr = s; wake_evt = w; irq_evt = i; dmode_wr = dw; dmode_wdata = dd;
    @(negedge clk);
    sleep_wr = 0; wake_evt = 0; irq_evt = 0; dmode_wr = 0; dmode_wdata = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_all("R1 reset", RUN, 0);
    cycle(0,0,0,0,0);
    expect_all("R1 idle after reset", RUN, 0);
  endtask

  task automatic t_enter_sleep();
    do_reset();
    cycle(1,0,0,0,0);
    expect_all("R2 run->sleep", SLP, 1);
    cycle(1,0,0,0,0);
    expect_all("R3 sleep_wr in sleep ignored", SLP, 1);
    cycle(0,0,0,1,0);
    expect_all("R5 clear ignored in sleep", SLP, 1);
    cycle(0,0,0,0,0);
    expect_all("R8 R9 sleep held", SLP, 1);
  endtask

  task automatic t_wake_paths();
    do_reset();
    cycle(1,0,0,0,0);
    cycle(0,1,0,0,0);
    expect_all("R3 wake -> intermediate", INT, 1);
    cycle(0,1,0,0,0);
    expect_all("R4 wake in intermediate no effect", INT, 1);
    cycle(1,0,0,0,0);
    expect_all("R7 inter->sleep", SLP, 1);
    cycle(0,0,1,0,0);
    expect_all("R3 irq -> intermediate, sref released R8", INT, 1);
    cycle(0,0,0,1,1);
    expect_all("R5 write 1 ignored in intermediate", INT, 1);
    cycle(0,0,0,1,0);
    expect_all("R6 clear -> run", RUN, 0);
  endtask

  task automatic t_run_events();
    do_reset();
    cycle(0,1,0,0,0);
    expect_all("R4 wake in run ignored", RUN, 0);
    cycle(0,0,1,0,0);
    expect_all("R4 irq in run ignored", RUN, 0);
    cycle(0,0,0,1,1);
    expect_all("R5 write 1 ignored in run", RUN, 0);
    cycle(1,1,0,0,0);
    expect_all("R10 wake beats sleep in run", RUN, 0);
    cycle(1,0,1,0,0);
    expect_all("R10 irq beats sleep in run", RUN, 0);
  endtask

  task automatic t_inter_priority();
    do_reset();
    cycle(1,0,0,0,0);
    cycle(0,1,0,0,0);
    cycle(1,0,1,0,0);
    expect_all("R10 irq beats sleep in intermediate", INT, 1);
    cycle(1,0,0,1,0);
    expect_all("R11 clear beats sleep in intermediate", RUN, 0);
    cycle(1,0,0,0,0);
    expect_all("R2 re-enter sleep from run", SLP, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_enter_sleep();
    t_wake_paths();
    t_run_events();
    t_inter_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule